// File: doc/BRIEF.md
# Address-Filtered Serial Receiver

This block receives asynchronous serial characters on a line shared by several nodes. The line is brought into the clock domain through a short flop chain and then sampled once per pulse of a tick input that runs at sixteen times the bit rate. A start is accepted only when the middle samples of the start bit confirm it. Each data bit is taken by a vote over the same middle samples. Characters of 8 or 9 data bits are assembled least significant bit first and are closed by one stop bit.

When address filtering is enabled, the top bit of every character marks it as an address or as data. An address character carries a target node number in its low four bits, and that number is compared with the node number set on an input. A node that has been asked to go quiet drops everything it receives until an address character naming it arrives. An address character naming some other node sends a listening node back to quiet. Characters that are kept land in a data register and raise a "character waiting" flag. A read strobe clears that flag, acting as the data-register read that a DMA engine or a CPU would issue.

Top module: `mcast_uart_rx`

## Requirements
- R1: The serial input passes through a two-flop synchroniser, and the receiver samples it only in cycles where `tick_i` is 1. Each bit lasts 16 ticks, and the receiver holds its state in cycles without a tick.
- R2: A low line seen on a tick while idle is sample 0 of a candidate start bit. The start is kept only if at least two of samples 7, 8 and 9 are low; otherwise the receiver returns to idle and nothing is produced.
- R3: Each data bit takes the majority value of its samples 7, 8 and 9, and bits arrive least significant first.
- R4: With `len9_i`=1 at start detection, a character has 9 data bits, reported in `data_o[8:0]`. With `len9_i`=0 it has 8 data bits and `data_o[8]` is 0.
- R5: If the stop bit votes low, `ferr_o` is set and the character is discarded: `data_o`, `rxne_o` and `muted_o` are left unchanged. A read strobe clears `ferr_o`, and a new framing error in the same cycle wins over the strobe.
- R6: A kept character loads `data_o` and sets `rxne_o` in the cycle after its stop-bit decision. `rd_i` clears `rxne_o` one cycle later, and a kept character that completes in the same cycle as a read leaves `rxne_o` at 1.
- R7: With `mute_en_i`=1, a character whose top data bit is 1 is an address. The top data bit is bit 7 for 8-bit characters and bit 8 for 9-bit characters. Its bits [3:0] are compared with `node_addr_i`. With `mute_en_i`=0, no character is treated as an address.
- R8: While `muted_o` is 1, data characters and address characters that do not match are discarded, and `data_o` and `rxne_o` keep their values.
- R9: A matching address character clears `muted_o` and is itself kept as received data.
- R10: With `mute_en_i`=1, an address character that does not match sets `muted_o` and is discarded, even when the receiver was not muted.
- R11: With `mute_en_i`=1, a `mute_req_i` pulse sets `muted_o` in the next cycle, but a matching address completing in the same cycle wins and leaves the receiver unmuted. `mute_en_i`=0 clears `muted_o`, after which every character is kept.
- R12: During reset, `data_o`=0, `rxne_o`=0, `muted_o`=0 and `ferr_o`=0, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Sampling pulse at 16x the bit rate |
| len9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| node_addr_i | input | 4 | Node number compared with address characters |
| mute_en_i | input | 1 | Enables address marking and muting |
| mute_req_i | input | 1 | Pulse that puts the receiver into mute |
| rd_i | input | 1 | Data-register read strobe |
| data_o | output | 9 | Last kept character |
| rxne_o | output | 1 | A kept character is waiting |
| muted_o | output | 1 | Receiver is muted |
| ferr_o | output | 1 | Framing error seen since the last read |

## Verification
Two pairs of events can land in one clock. In the first, a character completes in the same cycle as a read strobe. In the second, a matching address completes in the same cycle as a mute request. The bench holds the strobe or the request high through a whole frame and drops it only in the cycle after its reference model reports the completion, so the two events are sure to coincide. The outcome is judged by `rxne_o` staying at 1 with the new data, and by `muted_o` ending at 0. A behavioural reference model, built on sample counting, checks the outputs in every clock on top of these directed checks.

// File: rtl/nrx_pkg.sv
package nrx_pkg;

  localparam int unsigned WORD_MAX = 9;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_phase_e;

  typedef struct packed {
    logic [WORD_MAX-1:0] bits;
    logic                wide;
    logic                stop_ok;
  } rx_char_t;

endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign chain_d[i] = d_i;
    end else begin : g_next
      assign chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nrx_bit_engine.sv
module nrx_bit_engine
  import nrx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     len9_i,
  output logic     done_o,
  output rx_char_t char_o
);

  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned SMID = OVS / 2;
  localparam int unsigned SLO  = SMID - 1;
  localparam int unsigned SHI  = SMID + 1;
  localparam int unsigned IW   = $clog2(WORD_MAX + 1);

  rx_phase_e           phase_q, phase_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                v_lo_q, v_lo_d;
  logic                v_mid_q, v_mid_d;
  logic [WORD_MAX-1:0] word_q, word_d;
  logic [IW-1:0]       idx_q, idx_d;
  logic                wide_q, wide_d;

  logic          maj;
  logic          at_end;
  logic [IW-1:0] last_idx;

  assign maj      = (v_lo_q & v_mid_q) | (v_lo_q & rx_i) | (v_mid_q & rx_i);
  assign at_end   = (cnt_q == CW'(OVS - 1));
  assign last_idx = wide_q ? IW'(WORD_MAX - 1) : IW'(WORD_MAX - 2);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    v_lo_d  = v_lo_q;
    v_mid_d = v_mid_q;
    word_d  = word_q;
    idx_d   = idx_q;
    wide_d  = wide_q;
    done_o  = 1'b0;
    if (tick_i) begin
      if (phase_q == RX_IDLE) begin
        if (!rx_i) begin
          phase_d = RX_START;
          cnt_d   = CW'(1);
          word_d  = '0;
          idx_d   = '0;
          wide_d  = len9_i;
        end
      end else begin
        cnt_d = at_end ? '0 : cnt_q + CW'(1);
        if (cnt_q == CW'(SLO))  v_lo_d  = rx_i;
        if (cnt_q == CW'(SMID)) v_mid_d = rx_i;
        case (phase_q)
          RX_START: begin
            if (cnt_q == CW'(SHI) && maj) phase_d = RX_IDLE;
            else if (at_end)              phase_d = RX_DATA;
          end
          RX_DATA: begin
            if (cnt_q == CW'(SHI)) word_d[idx_q] = maj;
            if (at_end) begin
              if (idx_q == last_idx) phase_d = RX_STOP;
              else                   idx_d   = idx_q + IW'(1);
            end
          end
          RX_STOP: begin
            if (cnt_q == CW'(SHI)) begin
              done_o  = 1'b1;
              phase_d = RX_IDLE;
            end
          end
          default: phase_d = RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= RX_IDLE;
      cnt_q   <= '0;
      v_lo_q  <= 1'b1;
      v_mid_q <= 1'b1;
      word_q  <= '0;
      idx_q   <= '0;
      wide_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      v_lo_q  <= v_lo_d;
      v_mid_q <= v_mid_d;
      word_q  <= word_d;
      idx_q   <= idx_d;
      wide_q  <= wide_d;
    end
  end

  assign char_o = {word_q, wide_q, maj};

  p_hold_without_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(phase_q) && $stable(cnt_q)));

  p_false_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_q == RX_START && cnt_q == CW'(SHI) && v_lo_q && v_mid_q)
      |=> (phase_q == RX_IDLE));

endmodule

// File: rtl/nrx_mute_ctrl.sv
module nrx_mute_ctrl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          stop_ok_i,
  input  logic          msb_i,
  input  logic [AW-1:0] field_i,
  input  logic [AW-1:0] node_addr_i,
  input  logic          mute_en_i,
  input  logic          mute_req_i,
  output logic          muted_o,
  output logic          accept_o
);

  logic muted_q, muted_d;
  logic good, is_addr, hit;

  assign good    = done_i & stop_ok_i;
  assign is_addr = mute_en_i & msb_i;
  assign hit     = (field_i == node_addr_i);

  always_comb begin
    accept_o = good && (is_addr ? hit : !muted_q);
    muted_d  = muted_q;
    if (!mute_en_i) begin
      muted_d = 1'b0;
    end else begin
      if (mute_req_i)      muted_d = 1'b1;
      if (good && is_addr) muted_d = !hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) muted_q <= 1'b0;
    else         muted_q <= muted_d;
  end

  assign muted_o = muted_q;

  p_match_unmutes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good && is_addr && hit) |=> !muted_o);

  p_foreign_mutes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good && is_addr && !hit) |=> muted_o);

  p_muted_discard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && muted_q && !(is_addr && hit)) |-> !accept_o);

  p_disable_unmutes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_en_i |=> !muted_o);

endmodule

// File: rtl/mcast_uart_rx.sv
module mcast_uart_rx
  import nrx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AW          = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic                tick_i,
  input  logic                len9_i,
  input  logic [AW-1:0]       node_addr_i,
  input  logic                mute_en_i,
  input  logic                mute_req_i,
  input  logic                rd_i,
  output logic [WORD_MAX-1:0] data_o,
  output logic                rxne_o,
  output logic                muted_o,
  output logic                ferr_o
);

  logic     rx_s;
  logic     done;
  rx_char_t chr;
  logic     msb;
  logic     accept;

  logic [WORD_MAX-1:0] data_q, data_d;
  logic                rxne_q, rxne_d;
  logic                ferr_q, ferr_d;

  nrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  nrx_bit_engine #(.OVS(OVS)) u_engine (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rx_i  (rx_s),
    .len9_i(len9_i),
    .done_o(done),
    .char_o(chr)
  );

  assign msb = chr.wide ? chr.bits[WORD_MAX-1] : chr.bits[WORD_MAX-2];

  nrx_mute_ctrl #(.AW(AW)) u_mute (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .stop_ok_i  (chr.stop_ok),
    .msb_i      (msb),
    .field_i    (chr.bits[AW-1:0]),
    .node_addr_i(node_addr_i),
    .mute_en_i  (mute_en_i),
    .mute_req_i (mute_req_i),
    .muted_o    (muted_o),
    .accept_o   (accept)
  );

  always_comb begin
    data_d = data_q;
    rxne_d = rxne_q;
    ferr_d = ferr_q;
    if (rd_i) begin
      rxne_d = 1'b0;
      ferr_d = 1'b0;
    end
    if (accept) begin
      data_d = chr.bits;
      rxne_d = 1'b1;
    end
    if (done && !chr.stop_ok) ferr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rxne_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      data_q <= data_d;
      rxne_q <= rxne_d;
      ferr_q <= ferr_d;
    end
  end

  assign data_o = data_q;
  assign rxne_o = rxne_q;
  assign ferr_o = ferr_q;

  p_set_beats_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (rxne_o && data_o == $past(chr.bits)));

  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !accept) |=> !rxne_o);

  p_bad_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !chr.stop_ok) |=> (ferr_o && $stable(data_o) && $stable(muted_o)));

  p_hold_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(data_o));

endmodule

// File: tb/mcast_uart_rx_bench.sv
module mcast_uart_rx_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       rx_i;
  logic       tick_i;
  logic       len9_i;
  logic [3:0] node_addr_i;
  logic       mute_en_i;
  logic       mute_req_i;
  logic       rd_i;
  logic [8:0] data_o;
  logic       rxne_o;
  logic       muted_o;
  logic       ferr_o;

  int n_chk = 0;
  int n_err = 0;
  int wd    = 0;
  bit fin   = 0;
  int tcnt  = 0;

  always #10 clk_i = ~clk_i;

  mcast_uart_rx u_mcast_uart_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .tick_i     (tick_i),
    .len9_i     (len9_i),
    .node_addr_i(node_addr_i),
    .mute_en_i  (mute_en_i),
    .mute_req_i (mute_req_i),
    .rd_i       (rd_i),
    .data_o     (data_o),
    .rxne_o     (rxne_o),
    .muted_o    (muted_o),
    .ferr_o     (ferr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // tick generator: one pulse every 4 clocks
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      tcnt   = 0;
      tick_i = 1'b0;
    end else begin
      tick_i = (tcnt == 3);
      tcnt   = (tcnt + 1) % 4;
    end
  end

  // behavioural reference model: counts samples since the start edge
  bit         m_s1, m_s2, m_busy, m_a, m_b, m_evt;
  int         m_n, m_nb;
  logic [8:0] m_word;
  logic [8:0] e_data;
  bit         e_rxne, e_muted, e_ferr;

  always @(posedge clk_i) begin
    bit done, stopv, mj, old_muted, msb, isaddr, hit;
    int ph, pos;
    done  = 0;
    stopv = 0;
    if (!rst_ni) begin
      m_s1 = 1; m_s2 = 1; m_busy = 0; m_a = 1; m_b = 1; m_n = 0; m_nb = 8;
      m_word = '0; e_data = '0; e_rxne = 0; e_muted = 0; e_ferr = 0; m_evt = 0;
    end else begin
      if (tick_i) begin
        if (!m_busy) begin
          if (!m_s2) begin
            m_busy = 1; m_n = 1; m_word = '0; m_nb = len9_i ? 9 : 8;
          end
        end else begin
          ph  = m_n % 16;
          pos = m_n / 16;
          if (ph == 7) m_a = m_s2;
          if (ph == 8) m_b = m_s2;
          if (ph == 9) begin
            mj = (int'(m_a) + int'(m_b) + int'(m_s2)) >= 2;
            if (pos == 0) begin
              if (mj) m_busy = 0;
            end else if (pos <= m_nb) begin
              m_word[pos-1] = mj;
            end else begin
              done = 1; stopv = mj; m_busy = 0;
            end
          end
          m_n++;
        end
      end
      old_muted = e_muted;
      if (rd_i) begin e_rxne = 0; e_ferr = 0; end
      if (!mute_en_i) e_muted = 0;
      else if (mute_req_i) e_muted = 1;
      if (done) begin
        if (!stopv) e_ferr = 1;
        else begin
          msb    = (m_nb == 9) ? m_word[8] : m_word[7];
          isaddr = mute_en_i && msb;
          hit    = (m_word[3:0] == node_addr_i);
          if (isaddr) e_muted = !hit;
          if (isaddr ? hit : !old_muted) begin
            e_data = m_word; e_rxne = 1;
          end
        end
      end
      m_evt = done;
      m_s2  = m_s1;
      m_s1  = rx_i;
    end
  end

  // per-clock comparison against the model (R1 sampling, R6 flag, R11 mute)
  always @(negedge clk_i) begin
    if (rst_ni && !fin)
      chk({data_o, rxne_o, muted_o, ferr_o} == {e_data, e_rxne, e_muted, e_ferr},
          "R1 model data/rxne/muted/ferr", int'({data_o, rxne_o, muted_o, ferr_o}),
          int'({e_data, e_rxne, e_muted, e_ferr}));
  end

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic put_bit(input logic b);
    @(negedge clk_i) rx_i = b;
    repeat (63) @(negedge clk_i);
  endtask

  task automatic send_char(input logic [8:0] w, input int nb, input logic stopv);
    put_bit(1'b0);
    for (int i = 0; i < nb; i++) put_bit(w[i]);
    put_bit(stopv);
    @(negedge clk_i) rx_i = 1'b1;
    repeat (128) @(negedge clk_i);
  endtask

  task automatic read_pulse();
    @(negedge clk_i) rd_i = 1'b1;
    @(negedge clk_i) rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic look(input string tag, input logic [8:0] d, input bit ne, input bit mu, input bit fe);
    chk(data_o == d,   {tag, " data_o"},  int'(data_o),  int'(d));
    chk(rxne_o == ne,  {tag, " rxne_o"},  int'(rxne_o),  int'(ne));
    chk(muted_o == mu, {tag, " muted_o"}, int'(muted_o), int'(mu));
    chk(ferr_o == fe,  {tag, " ferr_o"},  int'(ferr_o),  int'(fe));
  endtask

  initial begin
    rst_ni = 1'b0; rx_i = 1'b1; len9_i = 1'b0; node_addr_i = 4'h5;
    mute_en_i = 1'b0; mute_req_i = 1'b0; rd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    look("R12 reset", 9'h000, 0, 0, 0);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);

    send_char(9'h035, 8, 1'b1);
    look("R3 8-bit char", 9'h035, 1, 0, 0);
    read_pulse();
    look("R6 read clears", 9'h035, 0, 0, 0);

    len9_i = 1'b1;
    send_char(9'h1A5, 9, 1'b1);
    look("R4 9-bit char", 9'h1A5, 1, 0, 0);
    read_pulse();
    len9_i = 1'b0;

    @(negedge clk_i) rx_i = 1'b0;
    repeat (19) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (300) @(negedge clk_i);
    look("R2 short low rejected", 9'h1A5, 0, 0, 0);

    send_char(9'h05A, 8, 1'b0);
    look("R5 framing error", 9'h1A5, 0, 0, 1);
    read_pulse();
    look("R5 read clears ferr", 9'h1A5, 0, 0, 0);

    mute_en_i = 1'b1;
    @(negedge clk_i) mute_req_i = 1'b1;
    @(negedge clk_i) mute_req_i = 1'b0;
    @(negedge clk_i);
    look("R11 mute request", 9'h1A5, 0, 1, 0);

    send_char(9'h023, 8, 1'b1);
    look("R8 data dropped", 9'h1A5, 0, 1, 0);
    send_char(9'h083, 8, 1'b1);
    look("R8 foreign address dropped", 9'h1A5, 0, 1, 0);
    send_char(9'h085, 8, 1'b1);
    look("R9 own address", 9'h085, 1, 0, 0);
    read_pulse();
    send_char(9'h042, 8, 1'b1);
    look("R7 data after match", 9'h042, 1, 0, 0);
    read_pulse();
    send_char(9'h087, 8, 1'b1);
    look("R10 foreign address mutes", 9'h042, 0, 1, 0);

    len9_i = 1'b1;
    send_char(9'h105, 9, 1'b1);
    look("R9 9-bit own address", 9'h105, 1, 0, 0);
    read_pulse();
    send_char(9'h08A, 9, 1'b1);
    look("R7 9-bit bit7 is data", 9'h08A, 1, 0, 0);
    read_pulse();
    len9_i = 1'b0;

    @(negedge clk_i) mute_req_i = 1'b1;
    @(negedge clk_i) mute_req_i = 1'b0;
    @(negedge clk_i) mute_en_i = 1'b0;
    @(negedge clk_i);
    look("R11 disable unmutes", 9'h08A, 0, 0, 0);
    send_char(9'h089, 8, 1'b1);
    look("R11 no address when disabled", 9'h089, 1, 0, 0);
    read_pulse();

    @(negedge clk_i) rd_i = 1'b1;
    fork
      send_char(9'h0C3, 8, 1'b1);
      begin
        while (!m_evt) @(negedge clk_i);
        rd_i = 1'b0;
      end
    join
    look("R6 set beats read", 9'h0C3, 1, 0, 0);
    read_pulse();

    mute_en_i = 1'b1;
    @(negedge clk_i) mute_req_i = 1'b1;
    fork
      send_char(9'h085, 8, 1'b1);
      begin
        while (!m_evt) @(negedge clk_i);
        mute_req_i = 1'b0;
      end
    join
    look("R11 match beats request", 9'h085, 1, 0, 0);

    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule